// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node side of a directory coherence scheme for a shared-memory multiprocessor that has no broadcast medium. For every memory block it owns, it keeps a directory entry made of a state (Uncached, Shared or Exclusive), a vector with one presence bit per processor, and an owner index. Requesting nodes send it read-miss and write-miss messages. The controller answers each one explicitly. Depending on the entry, it first sends invalidations to the other holders or asks the current owner to return its dirty copy, and only then grants the access.

Requests go into a small in-order queue. The controller serves them one at a time, so a block never has two transactions open at once. A requester is taken to be stalled until its reply arrives.

The controller is built around one state machine:
- IDLE takes the oldest queued request.
- DECIDE looks up the entry and picks the path.
- INVAL sends one invalidation message that carries a target mask.
- WAIT_INV collects the acknowledgements.
- FETCH sends a recall to the owner.
- WAIT_WB waits for the owner's write-back.
- REPLY grants the request and writes the updated entry.

The transitions are as follows:
- IDLE→DECIDE when the queue is not empty.
- DECIDE→REPLY for an Uncached entry, for a read of a Shared entry, for a write to a Shared entry that has no other holder, and for an Exclusive entry that the requester already owns.
- DECIDE→INVAL for a write to a Shared entry that has other holders.
- DECIDE→FETCH for an Exclusive entry owned by another node.
- INVAL→REPLY when the acks complete on that edge. Otherwise INVAL→WAIT_INV.
- WAIT_INV→REPLY on the last acknowledgement.
- FETCH→REPLY when the owner answers on that edge. Otherwise FETCH→WAIT_WB.
- WAIT_WB→REPLY on the owner's response.
- REPLY→IDLE.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is Uncached with no holders. `req_ready` is 1, and `reply_valid`, `inv_valid` and `fetch_valid` are 0.
- R2: A read miss (`req_write`=0) to an Uncached block is answered with `reply_excl`=0. `reply_valid` is high in the cycle that starts two rising edges after the edge that accepts the request. The entry becomes Shared with only the requester's bit set.
- R3: A read miss to a Shared block is answered with `reply_excl`=0, and no invalidation or fetch is sent. The requester's bit is added to the existing holders.
- R4: A write miss (`req_write`=1) to a Shared block with other holders sends one invalidation. Its `inv_mask` has bit i set for every holder i other than the requester. The reply (`reply_excl`=1) comes only after a response (`rsp_valid`) has arrived from every node in that mask. The requester then becomes the only holder and the owner, and the entry becomes Exclusive.
- R5: A write miss to an Uncached block, or to a Shared block whose only holder is the requester, is answered with `reply_excl`=1 without any invalidation. The requester becomes the owner.
- R6: A read miss to an Exclusive block owned by another node sends a fetch to the owner with `fetch_inval`=0. The reply follows the owner's response. Afterwards, both the former owner and the requester are holders of a Shared entry.
- R7: A write miss to an Exclusive block owned by another node sends a fetch to the owner with `fetch_inval`=1. The reply (`reply_excl`=1) follows the owner's response, and ownership moves to the requester.
- R8: While the controller waits for responses, a response from a node it is not waiting on has no effect, and no reply is issued.
- R9: Requests wait in a queue of `QDEPTH` entries and are served in arrival order. When `QDEPTH` requests are waiting, `req_ready` is 0.
- R10: At most one of `reply_valid`, `inv_valid` and `fetch_valid` is high in any cycle. An invalidation never targets the requester, and a fetch never targets the requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request message is offered |
| req_ready | output | 1 | The queue can take a request |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_node | input | NW | Requesting processor |
| req_blk | input | BW | Block addressed |
| reply_valid | output | 1 | Grant message to the requester |
| reply_node | output | NW | Destination of the grant |
| reply_blk | output | BW | Block granted |
| reply_excl | output | 1 | 1 = write permission granted |
| inv_valid | output | 1 | Invalidation message |
| inv_mask | output | NPROC | Nodes to invalidate |
| inv_blk | output | BW | Block to invalidate |
| fetch_valid | output | 1 | Recall message to the owner |
| fetch_node | output | NW | Owner being recalled |
| fetch_blk | output | BW | Block recalled |
| fetch_inval | output | 1 | 1 = owner must also drop its copy |
| rsp_valid | input | 1 | Response (ack or write-back) from a remote node |
| rsp_node | input | NW | Node giving the response |

## Verification
A corrupted presence vector or owner field is not visible when it is written. It shows up at the next transaction to that block, as a wrong `inv_mask`, a fetch sent to the wrong node, or a reply sent while an invalidation was owed. For that reason, each scenario follows an entry update with a second request to the same block whose messages expose the stored holders and owner. A wrong sequencing state shows up within a few cycles: a reply that arrives before the last acknowledgement, a stray response that completes a recall, or queued replies that come out of arrival order.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [1:0] {
        DS_UNC = 2'd0,
        DS_SHR = 2'd1,
        DS_EXC = 2'd2
    } dir_state_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECIDE,
        S_INVAL,
        S_WAIT_INV,
        S_FETCH,
        S_WAIT_WB,
        S_REPLY
    } home_fsm_e;
endpackage

// File: rtl/dir_req_fifo.sv
module dir_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  slot_q [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [AW:0]   cnt_q;

    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign empty = (cnt_q == '0);
    assign dout  = slot_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) begin
                slot_q[wr_ptr_q] <= din;
                wr_ptr_q <= (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop)
                rd_ptr_q <= (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
            if (push && !pop)
                cnt_q <= cnt_q + 1'b1;
            else if (pop && !push)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // R9: the queue never takes a request beyond its depth
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    // R9: the controller only dequeues a waiting request
    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dir_entry_table.sv
module dir_entry_table
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 4,
    localparam int NW = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    rd_blk,
    output dir_state_e       rd_state,
    output logic [NPROC-1:0] rd_shr,
    output logic [NW-1:0]    rd_own,
    input  logic             wr_en,
    input  logic [BW-1:0]    wr_blk,
    input  dir_state_e       wr_state,
    input  logic [NPROC-1:0] wr_shr,
    input  logic [NW-1:0]    wr_own
);
    dir_state_e       st_q  [NBLK];
    logic [NPROC-1:0] shr_q [NBLK];
    logic [NW-1:0]    own_q [NBLK];

    assign rd_state = st_q[rd_blk];
    assign rd_shr   = shr_q[rd_blk];
    assign rd_own   = own_q[rd_blk];

    for (genvar b = 0; b < NBLK; b++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[b]  <= DS_UNC;
                shr_q[b] <= '0;
                own_q[b] <= '0;
            end else if (wr_en && wr_blk == BW'(b)) begin
                st_q[b]  <= wr_state;
                shr_q[b] <= wr_shr;
                own_q[b] <= wr_own;
            end
        end
    end

    // R7: an Exclusive entry always records exactly one holder
    p_excl_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == DS_EXC) |-> ($countones(wr_shr) == 1));
    // R3: a Shared entry always has at least one holder
    p_shr_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == DS_SHR) |-> (wr_shr != '0));
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int NBLK   = 4,
    parameter int QDEPTH = 4,
    localparam int NW = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int QW = 1 + NW + BW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [NW-1:0]    req_node,
    input  logic [BW-1:0]    req_blk,
    output logic             reply_valid,
    output logic [NW-1:0]    reply_node,
    output logic [BW-1:0]    reply_blk,
    output logic             reply_excl,
    output logic             inv_valid,
    output logic [NPROC-1:0] inv_mask,
    output logic [BW-1:0]    inv_blk,
    output logic             fetch_valid,
    output logic [NW-1:0]    fetch_node,
    output logic [BW-1:0]    fetch_blk,
    output logic             fetch_inval,
    input  logic             rsp_valid,
    input  logic [NW-1:0]    rsp_node
);
    home_fsm_e state_q, state_d;

    logic             q_push, q_pop, q_full, q_empty;
    logic [QW-1:0]    q_dout;
    logic             cur_write;
    logic [NW-1:0]    cur_node;
    logic [BW-1:0]    cur_blk;
    logic [NPROC-1:0] pend_q, pend_d, pend_n;
    logic [NPROC-1:0] req_bit, rsp_bit, others;

    dir_state_e       ent_state, wr_state;
    logic [NPROC-1:0] ent_shr, wr_shr;
    logic [NW-1:0]    ent_own, wr_own;
    logic             tbl_wr;
    logic             owner_rsp;

    assign req_ready = !q_full;
    assign q_push    = req_valid && !q_full;
    assign q_pop     = (state_q == S_IDLE) && !q_empty;

    dir_req_fifo #(.W(QW), .DEPTH(QDEPTH)) req_q_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   ({req_write, req_node, req_blk}),
        .pop   (q_pop),
        .dout  (q_dout),
        .full  (q_full),
        .empty (q_empty)
    );

    dir_entry_table #(.NPROC(NPROC), .NBLK(NBLK)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_blk   (cur_blk),
        .rd_state (ent_state),
        .rd_shr   (ent_shr),
        .rd_own   (ent_own),
        .wr_en    (tbl_wr),
        .wr_blk   (cur_blk),
        .wr_state (wr_state),
        .wr_shr   (wr_shr),
        .wr_own   (wr_own)
    );

    always_comb begin
        req_bit = '0;
        req_bit[cur_node] = 1'b1;
        rsp_bit = '0;
        if (rsp_valid) rsp_bit[rsp_node] = 1'b1;
    end

    assign others    = ent_shr & ~req_bit;
    assign pend_n    = pend_q & ~rsp_bit;
    assign owner_rsp = rsp_valid && (rsp_node == ent_own);

    // next-state logic
    always_comb begin
        state_d = state_q;
        pend_d  = pend_n;
        unique case (state_q)
            S_IDLE:   if (!q_empty) state_d = S_DECIDE;
            S_DECIDE: begin
                pend_d = '0;
                unique case (ent_state)
                    DS_UNC: state_d = S_REPLY;
                    DS_SHR: begin
                        if (cur_write && others != '0) begin
                            pend_d  = others;
                            state_d = S_INVAL;
                        end else begin
                            state_d = S_REPLY;
                        end
                    end
                    default: state_d = (ent_own == cur_node) ? S_REPLY : S_FETCH;
                endcase
            end
            S_INVAL:    state_d = (pend_n == '0) ? S_REPLY : S_WAIT_INV;
            S_WAIT_INV: if (pend_n == '0) state_d = S_REPLY;
            S_FETCH:    state_d = owner_rsp ? S_REPLY : S_WAIT_WB;
            S_WAIT_WB:  if (owner_rsp) state_d = S_REPLY;
            S_REPLY:    state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transaction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_node  <= '0;
            cur_blk   <= '0;
            pend_q    <= '0;
        end else begin
            if (q_pop) {cur_write, cur_node, cur_blk} <= q_dout;
            pend_q <= pend_d;
        end
    end

    // outputs
    always_comb begin
        reply_valid = 1'b0;
        inv_valid   = 1'b0;
        fetch_valid = 1'b0;
        tbl_wr      = 1'b0;
        wr_state    = DS_SHR;
        wr_shr      = ent_shr | req_bit;
        wr_own      = ent_own;
        unique case (state_q)
            S_INVAL: inv_valid   = 1'b1;
            S_FETCH: fetch_valid = 1'b1;
            S_REPLY: begin
                reply_valid = 1'b1;
                tbl_wr      = 1'b1;
                if (cur_write) begin
                    wr_state = DS_EXC;
                    wr_shr   = req_bit;
                    wr_own   = cur_node;
                end
            end
            default: ;
        endcase
    end

    assign reply_node  = cur_node;
    assign reply_blk   = cur_blk;
    assign reply_excl  = cur_write;
    assign inv_mask    = pend_q;
    assign inv_blk     = cur_blk;
    assign fetch_node  = ent_own;
    assign fetch_blk   = cur_blk;
    assign fetch_inval = cur_write;

    // R10: one outgoing message per cycle
    p_one_msg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reply_valid, inv_valid, fetch_valid}));
    // R10: invalidation spares the requester and names at least one node
    p_inv_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (!inv_mask[cur_node] && inv_mask != '0));
    // R4: no grant while acknowledgements are still owed
    p_reply_after_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid |-> (pend_q == '0));
    // R10: a recall never goes to the requester
    p_fetch_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (fetch_node != cur_node));
    // R8: a recall completes only on the owner's response
    p_wb_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_WB && !owner_rsp) |=> (state_q == S_WAIT_WB));
endmodule

// File: tb/dir_home_ctrl_tb_top.sv
module dir_home_ctrl_tb_top;
    localparam int NPROC = 4;
    localparam int NBLK  = 4;
    localparam int NW    = 2;
    localparam int BW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [NW-1:0] req_node = '0;
    logic [BW-1:0] req_blk = '0;
    logic rsp_valid = 1'b0;
    logic [NW-1:0] rsp_node = '0;
    logic req_ready, reply_valid, reply_excl, inv_valid, fetch_valid, fetch_inval;
    logic [NW-1:0] reply_node, fetch_node;
    logic [BW-1:0] reply_blk, inv_blk, fetch_blk;
    logic [NPROC-1:0] inv_mask;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dir_home_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .QDEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_node(req_node), .req_blk(req_blk),
        .reply_valid(reply_valid), .reply_node(reply_node),
        .reply_blk(reply_blk), .reply_excl(reply_excl),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_blk(inv_blk),
        .fetch_valid(fetch_valid), .fetch_node(fetch_node),
        .fetch_blk(fetch_blk), .fetch_inval(fetch_inval),
        .rsp_valid(rsp_valid), .rsp_node(rsp_node)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_req(input bit w, input int node, input int blk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w;
        req_node = NW'(node); req_blk = BW'(blk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_rsp(input int node);
        rsp_valid = 1'b1; rsp_node = NW'(node);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic expect_reply(input int node, input int blk, input bit excl,
                                input string tag, output int waited);
        bit got = 0, stray = 0;
        waited = 0;
        while (!got && waited < 40) begin
            if (reply_valid) got = 1;
            else begin
                if (inv_valid || fetch_valid) stray = 1;
                @(negedge clk);
                waited++;
            end
        end
        check(got, {tag, " reply seen"}, got, 1);
        if (got) begin
            check(reply_node == NW'(node), {tag, " reply node"}, reply_node, node);
            check(reply_blk == BW'(blk), {tag, " reply blk"}, reply_blk, blk);
            check(reply_excl == excl, {tag, " reply excl"}, reply_excl, excl);
            @(negedge clk);
        end
        check(!stray, {tag, " no inval/fetch before reply"}, stray, 0);
    endtask

    task automatic expect_inv(input int mask, input int blk, input string tag);
        bit got = 0;
        int n = 0;
        while (!got && n < 40) begin
            if (inv_valid) got = 1;
            else begin @(negedge clk); n++; end
        end
        check(got, {tag, " inval seen"}, got, 1);
        if (got) begin
            check(inv_mask == NPROC'(mask), {tag, " inval mask"}, inv_mask, mask);
            check(inv_blk == BW'(blk), {tag, " inval blk"}, inv_blk, blk);
            @(negedge clk);
        end
    endtask

    task automatic expect_fetch(input int node, input int blk, input bit inval, input string tag);
        bit got = 0;
        int n = 0;
        while (!got && n < 40) begin
            if (fetch_valid) got = 1;
            else begin @(negedge clk); n++; end
        end
        check(got, {tag, " fetch seen"}, got, 1);
        if (got) begin
            check(fetch_node == NW'(node), {tag, " fetch node"}, fetch_node, node);
            check(fetch_blk == BW'(blk), {tag, " fetch blk"}, fetch_blk, blk);
            check(fetch_inval == inval, {tag, " fetch inval"}, fetch_inval, inval);
            @(negedge clk);
        end
    endtask

    task automatic no_reply(input int cycles, input string tag);
        bit seen = 0;
        for (int i = 0; i < cycles; i++) begin
            if (reply_valid) seen = 1;
            @(negedge clk);
        end
        check(!seen, {tag, " no early reply"}, seen, 0);
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check({reply_valid, inv_valid, fetch_valid} == 3'b000, "R1 outputs idle",
              {reply_valid, inv_valid, fetch_valid}, 0);
    endtask

    task automatic t_read_uncached();
        int w;
        send_req(1'b0, 0, 0);
        expect_reply(0, 0, 1'b0, "R2", w);
        check(w == 2, "R2 reply latency", w, 2);
    endtask

    task automatic t_read_shared();
        int w;
        send_req(1'b0, 1, 0);
        expect_reply(1, 0, 1'b0, "R3", w);
    endtask

    task automatic t_write_shared();
        int w;
        send_req(1'b1, 2, 0);
        expect_inv(4'b0011, 0, "R4");
        send_rsp(0);
        no_reply(3, "R4 one ack owed");
        send_rsp(1);
        expect_reply(2, 0, 1'b1, "R4", w);
    endtask

    task automatic t_write_excl();
        int w;
        send_req(1'b1, 3, 0);
        expect_fetch(2, 0, 1'b1, "R7");
        send_rsp(1);
        no_reply(3, "R8 stray response");
        send_rsp(2);
        expect_reply(3, 0, 1'b1, "R7", w);
    endtask

    task automatic t_read_excl();
        int w;
        send_req(1'b0, 0, 0);
        expect_fetch(3, 0, 1'b0, "R6 owner moved R7");
        send_rsp(3);
        expect_reply(0, 0, 1'b0, "R6", w);
        send_req(1'b1, 1, 0);
        expect_inv(4'b1001, 0, "R6 both holders");
        send_rsp(0);
        send_rsp(3);
        expect_reply(1, 0, 1'b1, "R6 follow-up", w);
    endtask

    task automatic t_write_noinv();
        int w;
        send_req(1'b1, 2, 1);
        expect_reply(2, 1, 1'b1, "R5 uncached", w);
        send_req(1'b0, 2, 2);
        expect_reply(2, 2, 1'b0, "R5 prep", w);
        send_req(1'b1, 2, 2);
        expect_reply(2, 2, 1'b1, "R5 sole holder", w);
    endtask

    task automatic t_queue();
        int w;
        send_req(1'b0, 3, 1);
        expect_fetch(2, 1, 1'b0, "R9 stall");
        for (int i = 0; i < 4; i++) begin
            req_valid = 1'b1; req_write = 1'b0;
            req_node = NW'(i); req_blk = BW'(3);
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9 full queue", req_ready, 0);
        send_rsp(2);
        expect_reply(3, 1, 1'b0, "R9 head", w);
        for (int i = 0; i < 4; i++) expect_reply(i, 3, 1'b0, "R9 order", w);
        check(req_ready == 1'b1, "R9 ready again", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_uncached();
        t_read_shared();
        t_write_shared();
        t_write_excl();
        t_read_excl();
        t_write_noinv();
        t_queue();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule